// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block makes the bit-rate clock for an asynchronous serial port, or the shift clock for a three-wire synchronous port. It does this either from a power-of-two prescale of the system clock or from an external clock pin. An 8-bit configuration register holds two nibbles. The low nibble picks the source that feeds the divider. The high nibble sets the divide ratio of a 5-bit counter. A toggle stage after the counter halves the rate again, so the output is a square wave.

All logic runs on the system clock. The chosen source and the counter wrap are one-cycle enables, not derived clocks. The external pin passes through a two-flop synchronizer and an edge detector. In asynchronous mode the detector reacts to both pin edges, which doubles the pin rate. In synchronous mode it reacts to rising edges only. Any write to the register restarts the whole divider chain at once, so software should write it only when the port is idle.

Top module: `baud_clk_gen`

## Requirements
- R1: After reset the register reads 0x00, and `out_clk` and `out_tick` are low.
- R2: `cfg_rdata` returns the last value written through `cfg_we`/`cfg_wdata` unchanged, and holds that value between writes.
- R3: A low-nibble code s in the range 0 to 14 selects the system clock prescaled by 2^s, that is, one source enable every 2^s cycles.
- R4: The high nibble r gives a counter ratio n = 16 + r (range 16 to 31). Each half period of `out_clk` lasts n source enables.
- R5: Low-nibble code 15 selects the external pin. With `async_mode` = 1, every rising and every falling pin edge is one source enable.
- R6: With code 15 and `async_mode` = 0, only rising pin edges are source enables.
- R7: A write clears the prescaler, the counter and the toggle stage at the write edge. With internal code s, `out_clk` first rises exactly n·2^s cycles after that edge.
- R8: `out_clk` is a 50% duty square wave: its high and low phases are equally long.
- R9: `out_tick` is high for exactly one cycle, the first cycle in which `out_clk` is high after a rise, and at no other time.
- R10: While an internal code is selected, activity on `ext_clk_in` has no effect on the output timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Write data: [7:4] ratio offset, [3:0] source code |
| cfg_rdata | output | 8 | Register read-back |
| async_mode | input | 1 | 1 = asynchronous port (both pin edges), 0 = synchronous port |
| ext_clk_in | input | 1 | External clock pin, at most one quarter of `clk` |
| out_clk | output | 1 | Divided square-wave output |
| out_tick | output | 1 | One-cycle pulse on each rise of `out_clk` |

## Verification
The bench measures the exact first-rise latency after a write for several source and ratio pairs. A missing or extra pipeline stage, or a ratio that is off by one, shifts that count. It rewrites the register in the middle of a half period. A chain that is not cleared by the write would rise early, at the old phase. With the external source it times the gap between ticks in both modes. A detector that ignores falling edges in asynchronous mode would double the gap, and one that counts them in synchronous mode would halve it. It also checks the high-phase length and runs the external pin during an internal selection, where a leaking source mux would disturb the timing.

// File: rtl/baud_pkg.sv
// Shared constants and the configuration register layout for the baud clock generator.
package baud_pkg;
    parameter int CFG_W   = 8;
    parameter int SEL_W   = 4;
    parameter int RATIO_W = CFG_W - SEL_W;
    // Source code that routes the external pin instead of the prescaler
    parameter logic [SEL_W-1:0] EXT_CODE = '1;

    // Register layout: ratio offset in the high nibble, source code in the low nibble
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [SEL_W-1:0]   src;
    } cfg_t;
endpackage

// File: rtl/bcg_prescaler.sv
// Power-of-two prescaler. A free-running counter is cleared by clr. en_o is high
// one cycle in every 2^sel_i cycles (every cycle when sel_i is 0).
// Assumes PRE_W is at least the largest internal source code.
module bcg_prescaler #(
    parameter int PRE_W = 14,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel_i,
    output logic             en_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Free-running count, restarted by reset or by a register write
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre_q <= '0;
        else               pre_q <= pre_q + 1'b1;
    end

    // Build the mask of the low sel_i bits that must all be ones
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (32'(sel_i) > i);
    end

    // Enable when every masked bit of the count is one
    always_comb en_o = &(pre_q | ~mask);
endmodule

// File: rtl/bcg_edge_det.sv
// Synchronizes the external clock pin with two flops, then flags its rising and
// falling edges as one-cycle pulses. Assumes the pin runs at no more than a
// quarter of clk.
module bcg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [2:0] sh_q;

    // Two synchronizer stages plus one history stage for edge compare
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], pin_i};
    end

    // Edge pulses from the synchronized level and its previous value
    always_comb begin
        rise_o = sh_q[1] & ~sh_q[2];
        fall_o = ~sh_q[1] & sh_q[2];
    end
endmodule

// File: rtl/bcg_divider.sv
// Divides the source enable by BASE + ratio_i with a counter, then halves it with
// a toggle flop to give a square wave. tick_o marks the first high cycle.
// Assumes BASE + max ratio fits in CNT_W bits.
module bcg_divider #(
    parameter int CNT_W   = 5,
    parameter int RATIO_W = 4,
    parameter int BASE    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               clk_o,
    output logic               tick_o
);
    localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(BASE - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;
    logic             wrap;
    logic             tog_q;
    logic             tick_q;

    // Terminal count and wrap condition for this ratio
    always_comb begin
        term = BASE_M1 + CNT_W'(ratio_i);
        wrap = en_i && (cnt_q == term);
    end

    // Source counter, restarted by reset or by a register write
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (wrap)     cnt_q <= '0;
        else if (en_i)     cnt_q <= cnt_q + 1'b1;
    end

    // Divide-by-two toggle driven by the counter wrap
    always_ff @(posedge clk) begin
        if (!rst_n || clr) tog_q <= 1'b0;
        else if (wrap)     tog_q <= ~tog_q;
    end

    // Rising-transition marker, aligned with the first high cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) tick_q <= 1'b0;
        else               tick_q <= wrap && !tog_q;
    end

    assign cnt_o  = cnt_q;
    assign clk_o  = tog_q;
    assign tick_o = tick_q;
endmodule

// File: rtl/baud_clk_gen.sv
// Programmable baud clock generator top. Holds the configuration register,
// selects the internal prescaled or external pin source, and feeds the divider.
// A register write clears the prescaler and divider chain at the write edge.
module baud_clk_gen
    import baud_pkg::*;
#(
    parameter int PRE_W = 14,
    parameter int CNT_W = 5,
    parameter int BASE  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             async_mode,
    input  logic             ext_clk_in,
    output logic             out_clk,
    output logic             out_tick
);
    cfg_t             cfg_q;
    logic             int_en;
    logic             ext_rise;
    logic             ext_fall;
    logic             ext_en;
    logic             src_en;
    logic [CNT_W-1:0] cnt_mon;

    // Configuration register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
    end

    bcg_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_we),
        .sel_i (cfg_q.src),
        .en_o  (int_en)
    );

    bcg_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_clk_in),
        .rise_o (ext_rise),
        .fall_o (ext_fall)
    );

    // Source mux: external edges (both in async mode) or the prescaler enable
    always_comb begin
        ext_en = ext_rise | (async_mode & ext_fall);
        src_en = (cfg_q.src == EXT_CODE) ? ext_en : int_en;
    end

    bcg_divider #(.CNT_W(CNT_W), .RATIO_W(RATIO_W), .BASE(BASE)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_we),
        .en_i    (src_en),
        .ratio_i (cfg_q.ratio),
        .cnt_o   (cnt_mon),
        .clk_o   (out_clk),
        .tick_o  (out_tick)
    );

    assign cfg_rdata = cfg_q;
endmodule

// File: rtl/bcg_checker.sv
// Property checker for baud_clk_gen, attached with bind.
module bcg_checker #(
    parameter int CNT_W = 5,
    parameter int BASE  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic [7:0]       cfg_rdata,
    input logic             out_clk,
    input logic             out_tick,
    input logic [CNT_W-1:0] cnt_val
);
    // R2
    rdata_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we) |-> cfg_rdata == $past(cfg_wdata));
    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_we) |-> $stable(cfg_rdata));
    // R7
    write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we) |-> (!out_clk && !out_tick));
    // R9
    tick_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> (out_clk && !$past(out_clk)));
    // R9
    rise_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_clk) |-> out_tick);
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_val) < BASE + 32'(cfg_rdata[7:4]));
endmodule

bind baud_clk_gen bcg_checker #(.CNT_W(CNT_W), .BASE(BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .out_clk   (out_clk),
    .out_tick  (out_tick),
    .cnt_val   (cnt_mon)
);

// File: tb/sim_baud_clk_gen.sv
module sim_baud_clk_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       async_mode = 1'b1;
    logic       ext_clk_in = 1'b0;
    logic       out_clk;
    logic       out_tick;
    logic       ext_run = 1'b0;
    int         total = 0;
    int         bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_clk_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .async_mode(async_mode), .ext_clk_in(ext_clk_in),
        .out_clk(out_clk), .out_tick(out_tick)
    );

    // External pin: toggles every 4 system cycles while enabled
    initial begin
        forever begin
            repeat (4) @(negedge clk);
            if (ext_run) ext_clk_in = ~ext_clk_in;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write the register; returns at the negedge after the write edge
    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R2 readback", int'(cfg_rdata), int'(v));
    endtask

    // From the negedge after the write (or reset) edge: rise at k, fall at 2k
    task automatic check_timing(input int k, input string req);
        repeat (k - 1) @(negedge clk);
        check({req, " low before rise"}, int'(out_clk), 0);
        @(negedge clk);
        check({req, " rise"}, int'(out_clk), 1);
        check("R9 tick at rise", int'(out_tick), 1);
        @(negedge clk);
        check("R9 tick one cycle", int'(out_tick), 0);
        repeat (k - 2) @(negedge clk);
        check("R8 high phase held", int'(out_clk), 1);
        @(negedge clk);
        check("R8 fall at 2k", int'(out_clk), 0);
    endtask

    // Measure the cycle gap between two successive ticks
    task automatic tick_gap(input int exp, input string req);
        int gap = 0;
        for (int i = 0; i < 4000 && !out_tick; i++) @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 4000 && !out_tick; i++) begin
            @(negedge clk);
            gap++;
        end
        check(req, gap + 1, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 rdata", int'(cfg_rdata), 0);
        check("R1 out_clk", int'(out_clk), 0);
        check("R1 out_tick", int'(out_tick), 0);
        rst_n = 1'b1;
        // Code 0, ratio 16: first rise 16 cycles after the reset release
        check_timing(16, "R4 reset default");
    endtask

    task automatic t_internal;
        write_cfg(8'hA5);
        write_cfg(8'h00);
        check_timing(16, "R3 R4 s0 n16");
        write_cfg(8'hF2);
        check_timing(31 * 4, "R3 R4 s2 n31");
        write_cfg(8'h43);
        check_timing(20 * 8, "R3 R4 s3 n20");
    endtask

    task automatic t_rewrite;
        write_cfg(8'h02);
        repeat (40) @(negedge clk);
        write_cfg(8'h02);
        check_timing(64, "R7 restart on write");
    endtask

    task automatic t_external;
        ext_run = 1'b1;
        async_mode = 1'b1;
        write_cfg(8'h0F);
        // Pin edges every 4 cycles, n=16: 64 per half, 128 per period
        tick_gap(128, "R5 async both edges");
        async_mode = 1'b0;
        write_cfg(8'h0F);
        tick_gap(256, "R6 sync rising only");
        // R10: internal source with pin active
        write_cfg(8'h10);
        check_timing(17, "R10 pin ignored");
        ext_run = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_internal();
        t_rewrite();
        t_external();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule